// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives a raw 8-bit asynchronous NAND flash bus on behalf of software. Software first loads a column register, a row register, a data register, a wait-count register and a geometry register through a simple register port. It then writes a control word that holds a mask of optional phases, the opcodes, a transfer length and a start bit. The engine runs the enabled phases in a fixed order and times every write or read strobe from the programmed wait counts. It clears the start bit once the last phase has finished.

The phases run in this order: first command byte, one special address byte or the column bytes, row bytes, second command byte with a long turnaround after it, then at most one 32-bit data word in either direction. A chip-select hold bit keeps CE# low after an operation completes. This lets a page transfer be built from many single-word operations inside one flash transaction. Software can also read the flash ready/busy line and an error flag through the control register.

Top module: `nflash_seq`

## Requirements
- R1: After reset CE#, WE# and RE# are high, CLE and ALE are low, and the start bit (control bit 31) reads 0.
- R2: Writing the control register (address 0) with bit 31 set while idle starts an operation. Bit 31 reads 1 until the last phase ends, then 0. Only enabled phases produce bus cycles, in the order: command 0 (bit 16), special address (bit 24) or column (bit 17), row (bit 18), command 1 (bit 19), data.
- R3: A command phase issues one WE# pulse with CLE high and ALE low. The byte is control bits 7:0 for the first command and bits 15:8 for the second.
- R4: Column cycles (address 1 register) send configuration bits 5:4 plus one bytes, and row cycles (address 2 register) send configuration bits 7:6 plus one bytes (configuration at address 5). Each byte goes out least significant first, with ALE high and CLE low.
- R5: With bit 24 set, exactly one address byte, column bits 7:0, is sent in place of the column cycles.
- R6: A data write (bit 21) sends control bits 29:28 plus one bytes from the data register (address 3), least significant first, with CLE and ALE low.
- R7: A data read (bit 20) issues bits 29:28 plus one RE# pulses. Each byte is captured at the RE# rising edge and packed little-endian into the data register, and the unused upper bytes read 0. DQ is never driven while RE# is low.
- R8: When bit 30 is set, CE# stays low after the operation completes. When it is clear, CE# returns high. WE# or RE# is only low while CE# is low.
- R9: The wait-count register (address 4) holds 6-bit fields at bits 0, 6, 12, 18 and 24 for setup, strobe low, strobe high, end hold and turnaround. A strobe stays low for the low count in cycles, with 0 acting as 1. Between two strobes of one phase it stays high for setup plus high plus one cycles.
- R10: Control bit 26 reads the level of the ready/busy input.
- R11: A start with both bits 20 and 21 set is rejected: no strobe, CE# unchanged, bit 31 reads 0 and bit 27 reads 1. The next accepted start clears bit 27.
- R12: Register writes while an operation runs are ignored. This includes the data register, whose old word is still sent and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Byte driven onto the flash bus |
| nf_dq_oe | output | 1 | Drive enable for nf_dq_out |
| nf_dq_in | input | 8 | Byte returned by the flash |
| nf_rb | input | 1 | Flash ready (1) / busy (0) |

## Verification
Random phase masks are combined with random opcodes, addresses, geometry, lengths and wait counts. Comparing the logged latch sequence exposes wrong phase order, wrong byte order and wrong byte counts. Directed runs cover the rest:
- the special single address byte, where a stray column byte would show;
- strobe width and gap measured in cycles, including a zero count;
- a write to the data register during a slow write, which separates an ignored write from a leaked one;
- the rejected read-plus-write start, where any bus activity or a missing error flag is caught.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

  typedef enum logic [3:0] {
    PH_IDLE = 4'd0,
    PH_CMD0 = 4'd1,
    PH_SPEC = 4'd2,
    PH_COL  = 4'd3,
    PH_ROW  = 4'd4,
    PH_CMD1 = 4'd5,
    PH_TURN = 4'd6,
    PH_DATA = 4'd7,
    PH_HOLD = 4'd8
  } phase_t;

  localparam int NPH = 9;

  localparam int RA_CTRL = 0;
  localparam int RA_COL  = 1;
  localparam int RA_ROW  = 2;
  localparam int RA_DATA = 3;
  localparam int RA_WAIT = 4;
  localparam int RA_CONF = 5;

  localparam int B_CMD0 = 16;
  localparam int B_COL  = 17;
  localparam int B_ROW  = 18;
  localparam int B_CMD1 = 19;
  localparam int B_RD   = 20;
  localparam int B_WR   = 21;
  localparam int B_SPEC = 24;
  localparam int B_RB   = 26;
  localparam int B_ERR  = 27;
  localparam int B_HOLD = 30;
  localparam int B_GO   = 31;

  // first enabled phase strictly after cur; HOLD always closes an operation
  function automatic phase_t nfs_next(input phase_t cur, input logic [31:0] ctl);
    logic [NPH-1:0] en;
    phase_t res;
    logic found;
    en = '0;
    en[PH_CMD0] = ctl[B_CMD0];
    en[PH_SPEC] = ctl[B_SPEC];
    en[PH_COL]  = ctl[B_COL] & ~ctl[B_SPEC];
    en[PH_ROW]  = ctl[B_ROW];
    en[PH_CMD1] = ctl[B_CMD1];
    en[PH_TURN] = ctl[B_CMD1];
    en[PH_DATA] = ctl[B_RD] | ctl[B_WR];
    en[PH_HOLD] = 1'b1;
    res = PH_IDLE;
    found = 1'b0;
    for (int i = 1; i < NPH; i++) begin
      if (!found && (i > int'(cur)) && en[i]) begin
        res = phase_t'(i[3:0]);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic nfs_is_byte(input phase_t ph);
    return (ph == PH_CMD0) || (ph == PH_SPEC) || (ph == PH_COL) ||
           (ph == PH_ROW) || (ph == PH_CMD1) || (ph == PH_DATA);
  endfunction

endpackage

// File: rtl/nfs_timer.sv
module nfs_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] count,
  output logic          expired
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load) cnt_q <= count;
    else if (cnt_q > ONE) cnt_q <= cnt_q - ONE;
  end

  assign expired = (cnt_q <= ONE);
endmodule

// File: rtl/nfs_strobe.sv
module nfs_strobe #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          rd_mode,
  input  logic [CW-1:0] t_setup,
  input  logic [CW-1:0] t_low,
  input  logic [CW-1:0] t_high,
  output logic          we_low,
  output logic          re_low,
  output logic          rise,
  output logic          last,
  output logic          idle
);
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH} st_t;

  st_t           st_q, st_d;
  logic          mode_q;
  logic          ld;
  logic [CW-1:0] tval;
  logic          exp_w;

  nfs_timer #(.CW(CW)) tmr_i (
    .clk(clk), .rst(rst), .load(ld), .count(tval), .expired(exp_w)
  );

  always_comb begin
    st_d = st_q;
    ld   = 1'b0;
    tval = t_setup;
    case (st_q)
      S_IDLE:  if (go) begin st_d = S_SETUP; ld = 1'b1; tval = t_setup; end
      S_SETUP: if (exp_w) begin st_d = S_LOW; ld = 1'b1; tval = t_low; end
      S_LOW:   if (exp_w) begin st_d = S_HIGH; ld = 1'b1; tval = t_high; end
      S_HIGH:  if (exp_w) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      mode_q <= 1'b0;
      we_low <= 1'b0;
      re_low <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && go) mode_q <= rd_mode;
      we_low <= (st_d == S_LOW) && !mode_q;
      re_low <= (st_d == S_LOW) && mode_q;
    end
  end

  assign rise = (st_q == S_LOW) && exp_w;
  assign last = (st_q == S_HIGH) && exp_w;
  assign idle = (st_q == S_IDLE);
endmodule

// File: rtl/nflash_seq.sv
module nflash_seq
  import nfs_pkg::*;
#(
  parameter int CW = 6,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic          nf_ce_n,
  output logic          nf_we_n,
  output logic          nf_re_n,
  output logic [7:0]    nf_dq_out,
  output logic          nf_dq_oe,
  input  logic [7:0]    nf_dq_in,
  input  logic          nf_rb
);
  localparam int WF = 5 * CW;

  logic [31:0]   ctl_q, col_q, row_q, data_q;
  logic [WF-1:0] wait_q;
  logic [7:0]    conf_q;
  logic          err_q, hold_q;
  phase_t        phase_q, ph_d, nx;
  logic [1:0]    idx_q, idx_d, nb_m1;
  logic          busy, start_req, bad_req, byte_ph, rd_mode;
  logic          s_go, s_rise, s_last, s_idle, s_we_low, s_re_low;
  logic          t_load, t_exp, hold_d;
  logic [CW-1:0] t_count;
  logic [CW-1:0] w_setup, w_low, w_high, w_hold, w_turn;
  logic          cle_q, ale_q, ce_n_q, oe_q;
  logic [7:0]    dq_q, byte_d;

  assign w_setup = wait_q[0*CW +: CW];
  assign w_low   = wait_q[1*CW +: CW];
  assign w_high  = wait_q[2*CW +: CW];
  assign w_hold  = wait_q[3*CW +: CW];
  assign w_turn  = wait_q[4*CW +: CW];

  assign busy      = (phase_q != PH_IDLE);
  assign start_req = reg_we && (reg_addr == AW'(RA_CTRL)) && reg_wdata[B_GO] && !busy;
  assign bad_req   = reg_wdata[B_RD] && reg_wdata[B_WR];
  assign byte_ph   = nfs_is_byte(phase_q);
  assign rd_mode   = (phase_q == PH_DATA) && ctl_q[B_RD];
  assign s_go      = byte_ph && s_idle;
  assign nx        = nfs_next(phase_q, ctl_q);

  always_comb begin
    case (phase_q)
      PH_COL:  nb_m1 = conf_q[5:4];
      PH_ROW:  nb_m1 = conf_q[7:6];
      PH_DATA: nb_m1 = ctl_q[29:28];
      default: nb_m1 = 2'd0;
    endcase
  end

  nfs_strobe #(.CW(CW)) strb_i (
    .clk(clk), .rst(rst), .go(s_go), .rd_mode(rd_mode),
    .t_setup(w_setup), .t_low(w_low), .t_high(w_high),
    .we_low(s_we_low), .re_low(s_re_low),
    .rise(s_rise), .last(s_last), .idle(s_idle)
  );

  nfs_timer #(.CW(CW)) gap_i (
    .clk(clk), .rst(rst), .load(t_load), .count(t_count), .expired(t_exp)
  );

  // phase walker
  always_comb begin
    ph_d    = phase_q;
    idx_d   = idx_q;
    t_load  = 1'b0;
    t_count = w_hold;
    if (phase_q == PH_IDLE) begin
      if (start_req && !bad_req) ph_d = nfs_next(PH_IDLE, reg_wdata);
    end else if (byte_ph && s_last) begin
      if (idx_q == nb_m1) begin
        ph_d  = nx;
        idx_d = 2'd0;
      end else begin
        idx_d = idx_q + 2'd1;
      end
    end else if ((phase_q == PH_TURN) && t_exp) begin
      ph_d = nx;
    end else if ((phase_q == PH_HOLD) && t_exp) begin
      ph_d = PH_IDLE;
    end
    if (ph_d != phase_q) begin
      if (ph_d == PH_TURN) begin
        t_load  = 1'b1;
        t_count = w_turn;
      end else if (ph_d == PH_HOLD) begin
        t_load  = 1'b1;
        t_count = w_hold;
      end
    end
  end

  assign hold_d = ((phase_q == PH_HOLD) && (ph_d == PH_IDLE)) ? ctl_q[B_HOLD] : hold_q;

  always_comb begin
    case (ph_d)
      PH_CMD0: byte_d = ctl_q[7:0];
      PH_CMD1: byte_d = ctl_q[15:8];
      PH_SPEC: byte_d = col_q[7:0];
      PH_COL:  byte_d = col_q[{idx_d, 3'b000} +: 8];
      PH_ROW:  byte_d = row_q[{idx_d, 3'b000} +: 8];
      PH_DATA: byte_d = data_q[{idx_d, 3'b000} +: 8];
      default: byte_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= 2'd0;
      hold_q  <= 1'b0;
      err_q   <= 1'b0;
      ctl_q   <= '0;
      col_q   <= '0;
      row_q   <= '0;
      data_q  <= '0;
      wait_q  <= '0;
      conf_q  <= '0;
    end else begin
      phase_q <= ph_d;
      idx_q   <= idx_d;
      hold_q  <= hold_d;
      if (reg_we && !busy) begin
        case (int'(reg_addr))
          RA_CTRL: begin
            ctl_q <= reg_wdata;
            if (reg_wdata[B_GO]) begin
              err_q <= bad_req;
              if (!bad_req && reg_wdata[B_RD]) data_q <= '0;
            end
          end
          RA_COL:  col_q  <= reg_wdata;
          RA_ROW:  row_q  <= reg_wdata;
          RA_DATA: data_q <= reg_wdata;
          RA_WAIT: wait_q <= reg_wdata[WF-1:0];
          RA_CONF: conf_q <= reg_wdata[7:0];
          default: ;
        endcase
      end
      if (s_rise && rd_mode) data_q[{idx_q, 3'b000} +: 8] <= nf_dq_in;
    end
  end

  // registered bus outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      ce_n_q <= 1'b1;
      oe_q   <= 1'b0;
      dq_q   <= 8'h00;
    end else begin
      cle_q  <= (ph_d == PH_CMD0) || (ph_d == PH_CMD1);
      ale_q  <= (ph_d == PH_SPEC) || (ph_d == PH_COL) || (ph_d == PH_ROW);
      ce_n_q <= !((ph_d != PH_IDLE) || hold_d);
      oe_q   <= (nfs_is_byte(ph_d) && (ph_d != PH_DATA)) ||
                ((ph_d == PH_DATA) && ctl_q[B_WR] && !ctl_q[B_RD]);
      dq_q   <= byte_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (int'(reg_addr))
        RA_CTRL: reg_rdata <= {busy, ctl_q[30:28], err_q, nf_rb, ctl_q[25:0]};
        RA_COL:  reg_rdata <= col_q;
        RA_ROW:  reg_rdata <= row_q;
        RA_DATA: reg_rdata <= data_q;
        RA_WAIT: reg_rdata <= 32'(wait_q);
        RA_CONF: reg_rdata <= 32'(conf_q);
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign nf_cle    = cle_q;
  assign nf_ale    = ale_q;
  assign nf_ce_n   = ce_n_q;
  assign nf_we_n   = ~s_we_low;
  assign nf_re_n   = ~s_re_low;
  assign nf_dq_out = dq_q;
  assign nf_dq_oe  = oe_q;
endmodule

// File: rtl/nfs_checker.sv
module nfs_checker (
  input logic clk,
  input logic rst,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic ce_n,
  input logic dq_oe,
  input logic busy
);
  // R3
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (rst) !(cle && ale));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n));
  // R8
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (rst) (!we_n || !re_n) |-> !ce_n);
  // R7
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst) !re_n |-> !dq_oe);
  // R2
  quiet_at_done_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (we_n && re_n));
endmodule

bind nflash_seq nfs_checker chk_i (
  .clk(clk), .rst(rst), .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n),
  .re_n(nf_re_n), .ce_n(nf_ce_n), .dq_oe(nf_dq_oe), .busy(busy)
);

// File: tb/nflash_seq_tb_top.sv
`timescale 1ns/1ps
module nflash_seq_tb_top;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          nf_cle, nf_ale, nf_ce_n, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0]    nf_dq_out;
  logic [7:0]    nf_dq_in = 8'h00;
  logic          nf_rb = 1'b1;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  nflash_seq #(.CW(6), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
    .nf_dq_in(nf_dq_in), .nf_rb(nf_rb)
  );

  // flash model: log latched bytes, serve read bytes
  logic [9:0] log_mem [0:31];
  int         log_n = 0;
  logic [7:0] rd_src [0:3];
  int         rd_n = 0;

  always @(posedge nf_we_n) begin
    if (nf_ce_n === 1'b0 && log_n < 32) begin
      log_mem[log_n] = {nf_cle, nf_ale, nf_dq_out};
      log_n = log_n + 1;
    end
  end

  always @(negedge nf_re_n) begin
    if (rd_n < 4) begin
      nf_dq_in = rd_src[rd_n];
      rd_n = rd_n + 1;
    end
  end

  logic [9:0] exp_mem [0:31];
  int         exp_n;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic push_exp(input logic [9:0] e);
    exp_mem[exp_n] = e;
    exp_n++;
  endtask

  task automatic build_exp(input logic [31:0] c, input logic [31:0] col, input logic [31:0] row,
                           input logic [7:0] cfg, input logic [31:0] dat);
    exp_n = 0;
    if (c[16]) push_exp({2'b10, c[7:0]});
    if (c[24]) push_exp({2'b01, col[7:0]});
    else if (c[17]) for (int i = 0; i <= int'(cfg[5:4]); i++) push_exp({2'b01, col[8*i +: 8]});
    if (c[18]) for (int i = 0; i <= int'(cfg[7:6]); i++) push_exp({2'b01, row[8*i +: 8]});
    if (c[19]) push_exp({2'b10, c[15:8]});
    if (c[21] && !c[20]) for (int i = 0; i <= int'(c[29:28]); i++) push_exp({2'b00, dat[8*i +: 8]});
  endtask

  task automatic launch(input logic [31:0] c, input logic [31:0] col, input logic [31:0] row,
                        input logic [7:0] cfg, input logic [31:0] dat);
    wr(1, col);
    wr(2, row);
    wr(5, 32'(cfg));
    wr(3, dat);
    log_n = 0;
    rd_n = 0;
    wr(0, c | 32'h8000_0000);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    bit done;
    done = 1'b0;
    for (int k = 0; k < 5000 && !done; k++) begin
      rd(0, v);
      if (!v[31]) done = 1'b1;
    end
    chk(done, "R2 start bit clears", 32'(done), 32'd1);
  endtask

  task automatic compare_log(input logic [31:0] c);
    logic [31:0] v, pk;
    chk(log_n == exp_n, "R2 latched byte count", 32'(log_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      if (exp_mem[i][9]) chk(log_mem[i] == exp_mem[i], "R3 command byte", 32'(log_mem[i]), 32'(exp_mem[i]));
      else if (exp_mem[i][8]) chk(log_mem[i] == exp_mem[i], "R4 address byte", 32'(log_mem[i]), 32'(exp_mem[i]));
      else chk(log_mem[i] == exp_mem[i], "R6 write byte", 32'(log_mem[i]), 32'(exp_mem[i]));
    end
    chk(nf_ce_n == !c[30], "R8 CE# after completion", 32'(nf_ce_n), 32'(!c[30]));
    if (c[20] && !c[21]) begin
      pk = '0;
      for (int i = 0; i <= int'(c[29:28]); i++) pk[8*i +: 8] = rd_src[i];
      rd(3, v);
      chk(v == pk, "R7 packed read word", v, pk);
      chk(rd_n == int'(c[29:28]) + 1, "R7 RE# pulse count", 32'(rd_n), 32'(c[29:28]) + 1);
    end
  endtask

  task automatic run_op(input logic [31:0] c, input logic [31:0] col, input logic [31:0] row,
                        input logic [7:0] cfg, input logic [31:0] dat);
    build_exp(c, col, row, cfg, dat);
    launch(c, col, row, cfg, dat);
    wait_done();
    compare_log(c);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    total++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, c, col, row, dat;
    logic [7:0]  cfg;
    int          cnt;
    logic        ce_before;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale, "R1 bus idle after reset",
        {27'd0, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 32'h1c);
    rd(0, v);
    chk(!v[31], "R1 start bit after reset", 32'(v[31]), 32'd0);

    // R10 ready/busy reflection
    nf_rb = 1'b0;
    rd(0, v);
    chk(v[26] == 1'b0, "R10 ready low", 32'(v[26]), 32'd0);
    nf_rb = 1'b1;
    rd(0, v);
    chk(v[26] == 1'b1, "R10 ready high", 32'(v[26]), 32'd1);

    // R2 start reads 1 right after launch, full phase walk
    wr(4, {2'd0, 6'd2, 6'd1, 6'd1, 6'd1, 6'd1});
    c = 32'h0000_3000 | 32'h000F_0000 | 32'h1000_0000 | 32'h0020_0000 | 32'h0000_0080;
    build_exp(c, 32'h0000_0201, 32'h0003_0201, 8'h50, 32'hCAFE_BEEF);
    launch(c, 32'h0000_0201, 32'h0003_0201, 8'h50, 32'hCAFE_BEEF);
    rd(0, v);
    chk(v[31], "R2 start bit while busy", 32'(v[31]), 32'd1);
    wait_done();
    compare_log(c);

    // R5 special single address byte replaces column cycles
    c = 32'h0000_0090 | (32'd1 << 16) | (32'd1 << 17) | (32'd1 << 24);
    build_exp(c, 32'h1234_5678, 32'h0, 8'h30, 32'h0);
    launch(c, 32'h1234_5678, 32'h0, 8'h30, 32'h0);
    wait_done();
    chk(log_n == 2, "R5 byte count", 32'(log_n), 32'd2);
    chk(log_mem[1] == {2'b01, 8'h78}, "R5 special address byte", 32'(log_mem[1]), 32'h178);

    // R9 strobe low width and gap
    wr(4, {2'd0, 6'd1, 6'd1, 6'd3, 6'd5, 6'd2});
    c = (32'd1 << 21) | (32'd1 << 28);
    build_exp(c, 0, 0, 8'h0, 32'h0000_A55A);
    launch(c, 0, 0, 8'h0, 32'h0000_A55A);
    cnt = 0;
    while (nf_we_n && cnt < 200) begin @(negedge clk); cnt++; end
    cnt = 0;
    while (!nf_we_n && cnt < 200) begin @(negedge clk); cnt++; end
    chk(cnt == 5, "R9 strobe low width", 32'(cnt), 32'd5);
    cnt = 0;
    while (nf_we_n && cnt < 200) begin @(negedge clk); cnt++; end
    chk(cnt == 6, "R9 strobe high gap", 32'(cnt), 32'd6);
    wait_done();
    compare_log(c);

    // R9 zero low count acts as one cycle
    wr(4, {2'd0, 6'd1, 6'd1, 6'd1, 6'd0, 6'd1});
    c = (32'd1 << 16) | 32'h0000_0070;
    build_exp(c, 0, 0, 8'h0, 0);
    launch(c, 0, 0, 8'h0, 0);
    cnt = 0;
    while (nf_we_n && cnt < 200) begin @(negedge clk); cnt++; end
    cnt = 0;
    while (!nf_we_n && cnt < 200) begin @(negedge clk); cnt++; end
    chk(cnt == 1, "R9 zero low count", 32'(cnt), 32'd1);
    wait_done();

    // R8 hold keeps CE# low, then release
    run_op((32'd1 << 30) | (32'd1 << 16) | 32'h0000_0080, 0, 0, 8'h0, 0);
    @(negedge clk);
    chk(!nf_ce_n, "R8 CE# held between operations", 32'(nf_ce_n), 32'd0);
    run_op((32'd1 << 21) | (32'd3 << 28), 0, 0, 8'h0, 32'h0403_0201);

    // R11 rejected read plus write
    ce_before = nf_ce_n;
    log_n = 0;
    rd_n = 0;
    wr(0, 32'h8000_0000 | (32'd1 << 20) | (32'd1 << 21) | (32'd1 << 16));
    repeat (20) @(negedge clk);
    chk(log_n == 0 && rd_n == 0, "R11 no strobes on reject", 32'(log_n + rd_n), 32'd0);
    chk(nf_ce_n == ce_before, "R11 CE# unchanged", 32'(nf_ce_n), 32'(ce_before));
    rd(0, v);
    chk(v[27] && !v[31], "R11 error flag set", {30'd0, v[31], v[27]}, 32'd1);
    run_op((32'd1 << 16) | 32'h0000_00FF, 0, 0, 8'h0, 0);
    rd(0, v);
    chk(!v[27], "R11 error flag cleared", 32'(v[27]), 32'd0);

    // R12 data register write during busy is ignored
    wr(4, {2'd0, 6'd4, 6'd20, 6'd20, 6'd20, 6'd20});
    c = (32'd1 << 21) | (32'd3 << 28);
    build_exp(c, 0, 0, 8'h0, 32'h1122_3344);
    launch(c, 0, 0, 8'h0, 32'h1122_3344);
    wr(3, 32'hDEAD_BEEF);
    wait_done();
    compare_log(c);
    rd(3, v);
    chk(v == 32'h1122_3344, "R12 data kept", v, 32'h1122_3344);

    // random operations
    for (int n = 0; n < 60; n++) begin
      int m;
      c = $urandom & 32'h0000_FFFF;
      c[16] = 1'($urandom); c[17] = 1'($urandom); c[18] = 1'($urandom);
      c[19] = 1'($urandom); c[24] = (($urandom % 5) == 0);
      m = int'($urandom % 3);
      c[20] = (m == 1); c[21] = (m == 2);
      c[29:28] = 2'($urandom); c[30] = 1'($urandom);
      col = $urandom; row = $urandom; dat = $urandom;
      cfg = {4'($urandom), 4'h0};
      for (int k = 0; k < 4; k++) rd_src[k] = 8'($urandom);
      wr(4, {2'd0, 6'($urandom % 4), 6'($urandom % 4), 6'($urandom % 4),
             6'($urandom % 4), 6'($urandom % 4)});
      run_op(c, col, row, cfg, dat);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule